// File: doc/BRIEF.md
# General-Purpose Pin Bank with Input Filtering and Wake Detection

This block controls a bank of general-purpose pins (32 by default). Each pin can be an input or an output. Its pad drive, output enable and pull resistors come from a set of software registers or, pin by pin, from a separate hardware control port. Incoming pad levels pass through a two-stage synchronizer. After that, an optional per-pin glitch filter runs on a shared sample tick. Edges of the filtered level are recorded in sticky status bits, which software clears by writing ones. A masked OR of those status bits drives a single interrupt line.

A separate wake-up path compares each synchronized (unfiltered) pin level with a per-pin programmed level. It raises the wake output whenever any wake-enabled pin matches its level. This path ignores the interrupt settings entirely and needs no state beyond the synchronizer flops.

Software reaches the bank through a simple register port. Writes are single-cycle strobes and reads are combinational from the address.

Top module: `gpio_bank`

## Requirements
- R1: After reset every configuration register and every status bit reads 0. The pads are then not driven (padOe = 0), no pull is applied, and irq and wake are both 0.
- R2: For a pin whose owner bit (OWNER, address 4) is 0, padOe follows its bit in DIR (address 0, 1 = output) and padOut follows its bit in DOUT (address 1).
- R3: For a pin whose OWNER bit is 1, padOut, padOe and the pull requests come from hwOut, hwOe, hwPu and hwPd instead of the registers.
- R4: The pull-up and pull-down requests of a pin come from PULLUP (address 2) and PULLDN (address 3), or from the hardware port when OWNER is set. padPu is driven only when the selected pull-up request is set and the selected pull-down request is clear, and the same rule applies to padPd the other way round. The two are never both 1.
- R5: With a pin's bit in FILTEN (address 5) clear, the level read from LEVEL (address 12, read only) equals the pad input three clock cycles after it changes.
- R6: With FILTEN set, a new pad level reaches LEVEL only after it has been seen on THRESH (address 13, 0 treated as 1) consecutive sample ticks, one tick every TICK_DIV clocks. A pulse seen on fewer ticks is discarded.
- R7: A rising edge of the filtered level sets the pin's status bit (STAT, address 9) when RISE (address 7) is set for that pin. A falling edge sets it when FALL (address 8) is set. Setting both captures either edge. Status bits stay set until cleared.
- R8: Writing STAT clears exactly the status bits written as 1. An edge arriving in the same cycle keeps its bit set.
- R9: irq is the OR over pins of STAT AND IRQEN (address 6). Status bits are recorded whatever IRQEN holds.
- R10: wake is 1 exactly when some pin has its WAKEEN (address 10) bit set and its synchronized level equals its WAKELVL (address 11) bit. This holds regardless of IRQEN, RISE, FALL and the glitch filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | W | Write data |
| regRdData | output | W | Read data for regAddr |
| hwOut | input | W | Hardware-owned output value |
| hwOe | input | W | Hardware-owned output enable |
| hwPu | input | W | Hardware-owned pull-up request |
| hwPd | input | W | Hardware-owned pull-down request |
| padIn | input | W | Pad input levels |
| padOut | output | W | Pad output value |
| padOe | output | W | Pad output enable |
| padPu | output | W | Pad pull-up enable |
| padPd | output | W | Pad pull-down enable |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
Some rules are checked on every cycle. The pull-up and pull-down enables are never both set. Hardware-owned pins show the hardware output enable. Status bits only fall in the cycle after a status write. A filtered pin only changes level after a sample tick, and wake stays low while no pin is wake-enabled.

Other behaviour needs the bench's scenarios. These include the exact filter threshold and the rejection of short glitches, and the mapping of rise, fall and both-edge selections onto status bits. They also include partial write-one-to-clear, interrupt masking, and the wake level comparison against random pad patterns.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR     = 4'd0,
    A_DOUT    = 4'd1,
    A_PULLUP  = 4'd2,
    A_PULLDN  = 4'd3,
    A_OWNER   = 4'd4,
    A_FILTEN  = 4'd5,
    A_IRQEN   = 4'd6,
    A_RISE    = 4'd7,
    A_FALL    = 4'd8,
    A_STAT    = 4'd9,
    A_WAKEEN  = 4'd10,
    A_WAKELVL = 4'd11,
    A_LEVEL   = 4'd12,
    A_THRESH  = 4'd13
  } regSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic stsW1c;    // clear status bits given by write data
    logic thrWr;     // threshold rewritten: realign sample tick
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [W-1:0]      regWrData,
  output logic [W-1:0]      regRdData,
  input  logic [W-1:0]      statusQ,
  input  logic [W-1:0]      filtIn,
  output logic [W-1:0]      dirQ,
  output logic [W-1:0]      doutQ,
  output logic [W-1:0]      pullUpQ,
  output logic [W-1:0]      pullDnQ,
  output logic [W-1:0]      hwSelQ,
  output logic [W-1:0]      dbEnQ,
  output logic [W-1:0]      irqEnQ,
  output logic [W-1:0]      riseEnQ,
  output logic [W-1:0]      fallEnQ,
  output logic [W-1:0]      wakeEnQ,
  output logic [W-1:0]      wakeLvlQ,
  output logic [CNT_W-1:0]  dbThrQ,
  output ctrlStrobe_t       strobe
);

  localparam int PAD_W = W - CNT_W;

  logic wrHit [14];

  always_comb begin
    for (int k = 0; k < 14; k++) begin
      wrHit[k] = regWrEn && (regAddr == ADDR_W'(k));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ     <= '0;
      doutQ    <= '0;
      pullUpQ  <= '0;
      pullDnQ  <= '0;
      hwSelQ   <= '0;
      dbEnQ    <= '0;
      irqEnQ   <= '0;
      riseEnQ  <= '0;
      fallEnQ  <= '0;
      wakeEnQ  <= '0;
      wakeLvlQ <= '0;
      dbThrQ   <= '0;
    end else begin
      if (wrHit[A_DIR])     dirQ     <= regWrData;
      if (wrHit[A_DOUT])    doutQ    <= regWrData;
      if (wrHit[A_PULLUP])  pullUpQ  <= regWrData;
      if (wrHit[A_PULLDN])  pullDnQ  <= regWrData;
      if (wrHit[A_OWNER])   hwSelQ   <= regWrData;
      if (wrHit[A_FILTEN])  dbEnQ    <= regWrData;
      if (wrHit[A_IRQEN])   irqEnQ   <= regWrData;
      if (wrHit[A_RISE])    riseEnQ  <= regWrData;
      if (wrHit[A_FALL])    fallEnQ  <= regWrData;
      if (wrHit[A_WAKEEN])  wakeEnQ  <= regWrData;
      if (wrHit[A_WAKELVL]) wakeLvlQ <= regWrData;
      if (wrHit[A_THRESH])  dbThrQ   <= regWrData[CNT_W-1:0];
    end
  end

  always_comb begin
    strobe.stsW1c = wrHit[A_STAT];
    strobe.thrWr  = wrHit[A_THRESH];
  end

  always_comb begin
    unique case (regAddr)
      A_DIR:     regRdData = dirQ;
      A_DOUT:    regRdData = doutQ;
      A_PULLUP:  regRdData = pullUpQ;
      A_PULLDN:  regRdData = pullDnQ;
      A_OWNER:   regRdData = hwSelQ;
      A_FILTEN:  regRdData = dbEnQ;
      A_IRQEN:   regRdData = irqEnQ;
      A_RISE:    regRdData = riseEnQ;
      A_FALL:    regRdData = fallEnQ;
      A_STAT:    regRdData = statusQ;
      A_WAKEEN:  regRdData = wakeEnQ;
      A_WAKELVL: regRdData = wakeLvlQ;
      A_LEVEL:   regRdData = filtIn;
      A_THRESH:  regRdData = {{PAD_W{1'b0}}, dbThrQ};
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int W        = 32,
  parameter int CNT_W    = 8,
  parameter int TICK_DIV = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [W-1:0]     wrData,
  input  logic [W-1:0]     dirQ,
  input  logic [W-1:0]     doutQ,
  input  logic [W-1:0]     pullUpQ,
  input  logic [W-1:0]     pullDnQ,
  input  logic [W-1:0]     hwSelQ,
  input  logic [W-1:0]     dbEnQ,
  input  logic [W-1:0]     irqEnQ,
  input  logic [W-1:0]     riseEnQ,
  input  logic [W-1:0]     fallEnQ,
  input  logic [W-1:0]     wakeEnQ,
  input  logic [W-1:0]     wakeLvlQ,
  input  logic [CNT_W-1:0] dbThrQ,
  input  logic [W-1:0]     hwOut,
  input  logic [W-1:0]     hwOe,
  input  logic [W-1:0]     hwPu,
  input  logic [W-1:0]     hwPd,
  input  logic [W-1:0]     padIn,
  output logic [W-1:0]     padOut,
  output logic [W-1:0]     padOe,
  output logic [W-1:0]     padPu,
  output logic [W-1:0]     padPd,
  output logic [W-1:0]     filtIn,
  output logic [W-1:0]     statusQ,
  output logic             tick,
  output logic             irq,
  output logic             wake
);

  localparam int TDW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [TDW-1:0] TICK_LAST = TDW'(TICK_DIV - 1);

  // pad control selection
  logic [W-1:0] puSel, pdSel;
  always_comb begin
    padOut = (hwSelQ & hwOut) | (~hwSelQ & doutQ);
    padOe  = (hwSelQ & hwOe)  | (~hwSelQ & dirQ);
    puSel  = (hwSelQ & hwPu)  | (~hwSelQ & pullUpQ);
    pdSel  = (hwSelQ & hwPd)  | (~hwSelQ & pullDnQ);
    padPu  = puSel & ~pdSel;
    padPd  = pdSel & ~puSel;
  end

  // input synchronizer
  logic [W-1:0] syncQ1, syncQ2;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ1 <= '0;
      syncQ2 <= '0;
    end else begin
      syncQ1 <= padIn;
      syncQ2 <= syncQ1;
    end
  end

  // shared sample tick
  logic [TDW-1:0] tickCnt;
  assign tick = (tickCnt == TICK_LAST);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tickCnt <= '0;
    else if (strobe.thrWr) tickCnt <= '0;
    else if (tick)         tickCnt <= '0;
    else                   tickCnt <= tickCnt + 1'b1;
  end

  logic [CNT_W-1:0] thrEff;
  assign thrEff = (dbThrQ == '0) ? CNT_W'(1) : dbThrQ;

  // per-pin glitch filter
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [CNT_W-1:0] cnt;
    logic             filt;
    logic [CNT_W:0]   cntNext;
    assign cntNext   = {1'b0, cnt} + 1'b1;
    assign filtIn[i] = filt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt  <= '0;
        filt <= 1'b0;
      end else if (!dbEnQ[i]) begin
        cnt  <= '0;
        filt <= syncQ2[i];
      end else if (syncQ2[i] == filt) begin
        cnt <= '0;
      end else if (tick) begin
        if (cntNext >= {1'b0, thrEff}) begin
          filt <= syncQ2[i];
          cnt  <= '0;
        end else begin
          cnt <= cntNext[CNT_W-1:0];
        end
      end
    end
  end

  // edge capture and sticky status
  logic [W-1:0] prevQ, evt, clrMask;
  always_comb begin
    evt     = (filtIn & ~prevQ & riseEnQ) | (~filtIn & prevQ & fallEnQ);
    clrMask = strobe.stsW1c ? wrData : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ   <= '0;
      statusQ <= '0;
    end else begin
      prevQ   <= filtIn;
      statusQ <= (statusQ & ~clrMask) | evt;
    end
  end

  assign irq  = |(statusQ & irqEnQ);
  assign wake = |(wakeEnQ & ~(syncQ2 ^ wakeLvlQ));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int W        = 32,
  parameter int CNT_W    = 8,
  parameter int TICK_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [W-1:0]      regWrData,
  output logic [W-1:0]      regRdData,
  input  logic [W-1:0]      hwOut,
  input  logic [W-1:0]      hwOe,
  input  logic [W-1:0]      hwPu,
  input  logic [W-1:0]      hwPd,
  input  logic [W-1:0]      padIn,
  output logic [W-1:0]      padOut,
  output logic [W-1:0]      padOe,
  output logic [W-1:0]      padPu,
  output logic [W-1:0]      padPd,
  output logic              irq,
  output logic              wake
);

  ctrlStrobe_t      strobe;
  logic             stsWr;
  logic             tick;
  logic [W-1:0]     statusQ, filtIn;
  logic [W-1:0]     dirQ, doutQ, pullUpQ, pullDnQ, hwSelQ, dbEnQ;
  logic [W-1:0]     irqEnQ, riseEnQ, fallEnQ, wakeEnQ, wakeLvlQ;
  logic [CNT_W-1:0] dbThrQ;

  assign stsWr = strobe.stsW1c;

  gpio_bank_ctrl #(.W(W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData),
    .statusQ(statusQ), .filtIn(filtIn),
    .dirQ(dirQ), .doutQ(doutQ), .pullUpQ(pullUpQ), .pullDnQ(pullDnQ),
    .hwSelQ(hwSelQ), .dbEnQ(dbEnQ), .irqEnQ(irqEnQ),
    .riseEnQ(riseEnQ), .fallEnQ(fallEnQ),
    .wakeEnQ(wakeEnQ), .wakeLvlQ(wakeLvlQ), .dbThrQ(dbThrQ),
    .strobe(strobe)
  );

  gpio_bank_dp #(.W(W), .CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .wrData(regWrData),
    .dirQ(dirQ), .doutQ(doutQ), .pullUpQ(pullUpQ), .pullDnQ(pullDnQ),
    .hwSelQ(hwSelQ), .dbEnQ(dbEnQ), .irqEnQ(irqEnQ),
    .riseEnQ(riseEnQ), .fallEnQ(fallEnQ),
    .wakeEnQ(wakeEnQ), .wakeLvlQ(wakeLvlQ), .dbThrQ(dbThrQ),
    .hwOut(hwOut), .hwOe(hwOe), .hwPu(hwPu), .hwPd(hwPd),
    .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padPu(padPu), .padPd(padPd),
    .filtIn(filtIn), .statusQ(statusQ), .tick(tick),
    .irq(irq), .wake(wake)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] padPu,
  input logic [W-1:0] padPd,
  input logic [W-1:0] padOe,
  input logic [W-1:0] hwOe,
  input logic [W-1:0] hwSelQ,
  input logic [W-1:0] statusQ,
  input logic         stsWr,
  input logic         tick,
  input logic [W-1:0] filtIn,
  input logic [W-1:0] dbEnQ,
  input logic [W-1:0] wakeEnQ,
  input logic         wake
);

  p_pull_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    (padPu & padPd) == '0);

  p_hw_oe_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe ^ hwOe) & hwSelQ) == '0);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stsWr |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  p_filter_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    (((filtIn ^ $past(filtIn)) & $past(dbEnQ)) != '0) |-> $past(tick));

  p_wake_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wakeEnQ == '0) |-> !wake);

endmodule

bind gpio_bank gpio_bank_chk #(.W(W)) u_chk (.*);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;

  localparam int W        = 32;
  localparam int CNT_W    = 8;
  localparam int TICK_DIV = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   regAddr = '0;
  logic         regWrEn = 1'b0;
  logic [W-1:0] regWrData = '0;
  logic [W-1:0] regRdData;
  logic [W-1:0] hwOut = '0, hwOe = '0, hwPu = '0, hwPd = '0, padIn = '0;
  logic [W-1:0] padOut, padOe, padPu, padPd;
  logic         irq, wake;

  int nChk = 0, nErr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank #(.W(W), .CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u0 (.*);

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    @(negedge clk);
    regAddr = a;
    #0.5 d = regRdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] selV(input logic [W-1:0] s, input logic [W-1:0] h, input logic [W-1:0] r);
    return (s & h) | (~s & r);
  endfunction

  function automatic logic [W-1:0] edgeSet(input logic [W-1:0] o, input logic [W-1:0] n,
                                           input logic [W-1:0] re, input logic [W-1:0] fe);
    return (~o & n & re) | (o & ~n & fe);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++; nChk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] d, dirV, outV, puV, pdV, selVal, re, fe, oldP, expSts, en, lvl;
    void'($urandom(32'd20240611));
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);

    // R1: reset state
    chk("R1 padOe", padOe, '0);
    chk("R1 pulls", padPu | padPd, '0);
    chk("R1 irq/wake", {30'd0, irq, wake}, '0);
    rd(4'd9, d);  chk("R1 status", d, '0);
    rd(4'd0, d);  chk("R1 dir", d, '0);

    // R2/R3/R4: random pad control
    for (int it = 0; it < 24; it++) begin
      dirV = $urandom; outV = $urandom; puV = $urandom; pdV = $urandom;
      selVal = (it < 6) ? '0 : ((it < 10) ? '1 : W'($urandom));
      hwOut = $urandom; hwOe = $urandom; hwPu = $urandom; hwPd = $urandom;
      wr(4'd0, dirV); wr(4'd1, outV); wr(4'd2, puV); wr(4'd3, pdV); wr(4'd4, selVal);
      waitCyc(1);
      chk("R2 R3 padOe", padOe, selV(selVal, hwOe, dirV));
      chk("R2 R3 padOut", padOut, selV(selVal, hwOut, outV));
      chk("R4 padPu", padPu, selV(selVal, hwPu, puV) & ~selV(selVal, hwPd, pdV));
      chk("R4 padPd", padPd, selV(selVal, hwPd, pdV) & ~selV(selVal, hwPu, puV));
    end
    // R4 corner: both pulls requested -> neither
    wr(4'd4, '0); wr(4'd2, '1); wr(4'd3, '1);
    waitCyc(1);
    chk("R4 both set", padPu | padPd, '0);

    // R5 and R7: unfiltered level and edge capture
    re = 32'h0000_FF0F; fe = 32'h00FF_000F;
    wr(4'd7, re); wr(4'd8, fe); wr(4'd9, '1);
    expSts = '0;
    oldP = padIn;
    for (int it = 0; it < 16; it++) begin
      @(negedge clk);
      padIn = $urandom;
      waitCyc(6);
      expSts |= edgeSet(oldP, padIn, re, fe);
      oldP = padIn;
      rd(4'd12, d); chk("R5 level", d, padIn);
      rd(4'd9, d);  chk("R7 status", d, expSts);
    end

    // R8: partial clear
    wr(4'd9, 32'h5555_5555);
    expSts &= ~32'h5555_5555;
    rd(4'd9, d); chk("R8 partial clear", d, expSts);

    // R9: masking
    wr(4'd6, '0); waitCyc(1);
    chk("R9 irq masked", {31'd0, irq}, '0);
    wr(4'd6, expSts); waitCyc(1);
    chk("R9 irq unmasked", {31'd0, irq}, {31'd0, (expSts != '0)});
    wr(4'd9, '1); waitCyc(1);
    chk("R9 irq after clear", {31'd0, irq}, '0);
    wr(4'd6, '0);

    // R6: glitch filter, threshold 3 ticks on pin 0
    @(negedge clk); padIn = '0; waitCyc(6);
    wr(4'd5, 32'h1); wr(4'd13, 32'd3);
    @(negedge clk); padIn = 32'h1;
    waitCyc(4);
    padIn = '0;
    waitCyc(20);
    rd(4'd12, d); chk("R6 glitch ignored", d & 32'h1, '0);
    @(negedge clk); padIn = 32'h1;
    waitCyc(6);
    rd(4'd12, d); chk("R6 not yet", d & 32'h1, '0);
    waitCyc(24);
    rd(4'd12, d); chk("R6 accepted", d & 32'h1, 32'h1);
    wr(4'd5, '0);

    // R10: wake, independent of interrupt settings
    wr(4'd6, '0); wr(4'd7, '0); wr(4'd8, '0);
    for (int it = 0; it < 24; it++) begin
      en = (it == 0) ? '0 : W'($urandom) & W'($urandom);
      lvl = $urandom;
      @(negedge clk); padIn = $urandom;
      if (it == 1) padIn = ~lvl;
      wr(4'd10, en); wr(4'd11, lvl);
      waitCyc(3);
      chk("R10 wake", {31'd0, wake}, {31'd0, |(en & ~(padIn ^ lvl))});
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

endmodule